// File: doc/BRIEF.md
# Link Wake Request Generator

This block sits in a physical-layer device. It decides when the attached link-layer controller has to be woken, and it drives the wake line as a square wave. The link counts as active only while both its power-status input and its link-control enable are high. While the link is inactive, any of four causes starts a wake burst:

- a wake packet addressed to this node;
- the port-event interrupt bit;
- one of the three gated interrupt bits, while the resuming-port interrupt enable is set;
- a power-cycle event whose power class is 0 to 4.

Every cause is held in a registered flag. The packet and power-cycle causes arrive as single-cycle pulses. The interrupt causes are levels. The burst stops when the link becomes active. A bus reset cancels a burst that rests only on a packet. A burst that rests only on a power cycle expires after a parameterised number of clock cycles. A pending interrupt starts a new burst as soon as the link drops again.

No data stream passes through the block, so every pin is a plain control or status signal and there is no handshake to apply back-pressure to. During reset the output is not driven: the output-enable is low.

Top module: `lkw_wake_gen`

## Requirements
- R1: While rst_n is low, wake_oe_o and wake_o are both 0. wake_oe_o is 1 from the first rising clock edge after reset is released.
- R2: With no cause present, wake_o stays 0.
- R3: An active burst is a square wave with a period of 2*HALF_CYC cycles (8 by default). It is high for the first HALF_CYC cycles after the edge that latched the cause, then low for HALF_CYC cycles, and so on.
- R4: A one-cycle pulse on wake_pkt_i while the link is inactive (link_pwr_on_i & link_ctl_en_i == 0) starts a burst in the cycle after the edge that samples it. The burst does not return by itself after the link has cleared it.
- R5: The cycle after an edge that samples the link as active, wake_o is 0, and no cause starts a burst while the link is active.
- R6: irq_port_event_i starts a burst on its own, whatever the value of irq_resume_en_i.
- R7: irq_cfg_timeout_i, irq_cable_pwr_i and irq_state_timeout_i start a burst only while irq_resume_en_i is 1.
- R8: A pwr_cycle_i pulse starts a burst when pwr_class_i (unsigned) is 0 to 4. Classes 5 to 7 are ignored.
- R9: A burst held only by the power-cycle cause stays on for exactly TIMEOUT_CYC cycles and then goes low. An interrupt that is sampled on or before the expiry edge keeps the burst running with no break in phase.
- R10: A bus_reset_i sample ends a burst whose only cause is a packet. It ends that burst even when the packet pulse arrives in the same cycle as the bus reset. A burst that an interrupt or a power cycle also holds continues.
- R11: An interrupt cause that is present while the link is active starts a burst in the cycle after the edge that first samples the link as inactive.
- R12: Each new burst restarts the phase, so its first HALF_CYC cycles are high.
- R13: Once latched, an interrupt cause keeps the burst running after its bits clear, until the link becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| link_pwr_on_i | input | 1 | Link power-status input |
| link_ctl_en_i | input | 1 | Link-control enable bit |
| wake_pkt_i | input | 1 | One-cycle pulse: wake packet for this node received |
| irq_port_event_i | input | 1 | Port-event interrupt bit |
| irq_cfg_timeout_i | input | 1 | Configuration-timeout interrupt bit |
| irq_cable_pwr_i | input | 1 | Cable-power-status interrupt bit |
| irq_state_timeout_i | input | 1 | State-timeout interrupt bit |
| irq_resume_en_i | input | 1 | Resuming-port interrupt enable |
| pwr_cycle_i | input | 1 | One-cycle pulse: power-cycle event |
| pwr_class_i | input | CLASS_W | Power class that goes with the power-cycle event |
| bus_reset_i | input | 1 | Bus-reset indication |
| wake_o | output | 1 | Wake square wave, low when idle |
| wake_oe_o | output | 1 | Output enable for wake_o, low during reset |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a bus-reset sample and a new packet pulse. The bench drives both before the same edge and expects no burst at all. It also drives a bus reset into a burst that a packet shares with an interrupt or a power cycle, and expects the wave to carry on without a break.

The second pair is the power-cycle expiry edge and a newly asserted interrupt. The bench raises the port-event bit exactly in the last cycle of the timeout window. It expects the square wave to continue in phase past the window, and judges every cycle against the period arithmetic.

// File: rtl/lkw_pkg.sv
package lkw_pkg;
  // Latched wake causes; any set flag keeps a burst running.
  typedef struct packed {
    logic pkt;   // one-shot: wake packet received
    logic intr;  // interrupt cause seen while link inactive
    logic pwr;   // one-shot: power-cycle event, time-limited
  } lkw_cause_t;
endpackage

// File: rtl/lkw_cause_track.sv
module lkw_cause_track
  import lkw_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8208384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_act,
  input  logic       pkt_evt,
  input  logic       int_live,
  input  logic       pwr_evt,
  input  logic       bus_reset,
  output lkw_cause_t cause_q
);
  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC + 1) : 1;

  logic [TW-1:0] tmr_q;
  logic          expire;

  assign expire = cause_q.pwr && (tmr_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (link_act) begin
      cause_q <= '0;
    end else begin
      // bus reset wins over a packet pulse in the same cycle
      cause_q.pkt  <= bus_reset ? 1'b0 : (cause_q.pkt | pkt_evt);
      cause_q.intr <= cause_q.intr | int_live;
      cause_q.pwr  <= expire ? 1'b0 : (cause_q.pwr | pwr_evt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (!cause_q.pwr || expire || link_act) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/lkw_wave_gen.sv
module lkw_wave_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic wave_o
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PW-1:0] ph_q;
  logic          lowhalf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= '0;
      lowhalf_q <= 1'b0;
    end else if (!active) begin
      ph_q      <= '0;
      lowhalf_q <= 1'b0;
    end else if (ph_q == PW'(HALF_CYC - 1)) begin
      ph_q      <= '0;
      lowhalf_q <= ~lowhalf_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // a fresh burst starts in its high half
  assign wave_o = active & ~lowhalf_q;
endmodule

// File: rtl/lkw_wake_gen.sv
module lkw_wake_gen
  import lkw_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int TIMEOUT_CYC = 8208384,
  parameter int CLASS_W     = 3,
  parameter int MAX_CLASS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_pwr_on_i,
  input  logic               link_ctl_en_i,
  input  logic               wake_pkt_i,
  input  logic               irq_port_event_i,
  input  logic               irq_cfg_timeout_i,
  input  logic               irq_cable_pwr_i,
  input  logic               irq_state_timeout_i,
  input  logic               irq_resume_en_i,
  input  logic               pwr_cycle_i,
  input  logic [CLASS_W-1:0] pwr_class_i,
  input  logic               bus_reset_i,
  output logic               wake_o,
  output logic               wake_oe_o
);
  logic       link_act;
  logic       int_live;
  logic       pwr_evt;
  logic       wake_active;
  logic       oe_q;
  lkw_cause_t cause_q;

  assign link_act = link_pwr_on_i & link_ctl_en_i;
  assign int_live = irq_port_event_i |
                    (irq_resume_en_i &
                     (irq_cfg_timeout_i | irq_cable_pwr_i | irq_state_timeout_i));
  assign pwr_evt  = pwr_cycle_i && (pwr_class_i <= CLASS_W'(MAX_CLASS));

  lkw_cause_track #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_act (link_act),
    .pkt_evt  (wake_pkt_i),
    .int_live (int_live),
    .pwr_evt  (pwr_evt),
    .bus_reset(bus_reset_i),
    .cause_q  (cause_q)
  );

  assign wake_active = |cause_q;

  lkw_wave_gen #(.HALF_CYC(HALF_CYC)) u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .active(wake_active),
    .wave_o(wake_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= 1'b1;
  end
  assign wake_oe_o = oe_q;
endmodule

// File: rtl/lkw_checker.sv
module lkw_checker #(
  parameter int HALF_CYC    = 4,
  parameter int TIMEOUT_CYC = 8208384
) (
  input logic clk,
  input logic rst_n,
  input logic link_pwr_on_i,
  input logic link_ctl_en_i,
  input logic wake_pkt_i,
  input logic bus_reset_i,
  input logic wake_o,
  input logic wake_oe_o,
  input logic active,
  input logic pkt_f,
  input logic int_f,
  input logic pwr_f,
  input logic int_live,
  input logic pwr_evt
);
  logic link_act;
  logic prev_w;
  int   run_c;
  int   pwr_run;

  assign link_act = link_pwr_on_i & link_ctl_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_w  <= 1'b0;
      run_c   <= 0;
      pwr_run <= 0;
    end else begin
      prev_w <= wake_o;
      if (!active)                         run_c <= 0;
      else if (run_c == 0 || wake_o != prev_w) run_c <= 1;
      else                                 run_c <= run_c + 1;
      pwr_run <= pwr_f ? pwr_run + 1 : 0;
    end
  end

  assert_undriven_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_oe_o |-> !wake_o);
  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> run_c <= HALF_CYC);
  assert_pkt_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pkt_i && !link_act && !bus_reset_i) |=> active);
  assert_link_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_act |=> !wake_o);
  assert_pwr_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_run <= TIMEOUT_CYC);
  assert_pkt_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && pkt_f && !int_f && !pwr_f && !int_live && !pwr_evt) |=> !active);
  assert_int_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (int_f && !link_act) |=> active);
endmodule

bind lkw_wake_gen lkw_checker #(
  .HALF_CYC   (HALF_CYC),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_pwr_on_i(link_pwr_on_i),
  .link_ctl_en_i(link_ctl_en_i),
  .wake_pkt_i   (wake_pkt_i),
  .bus_reset_i  (bus_reset_i),
  .wake_o       (wake_o),
  .wake_oe_o    (wake_oe_o),
  .active       (wake_active),
  .pkt_f        (cause_q.pkt),
  .int_f        (cause_q.intr),
  .pwr_f        (cause_q.pwr),
  .int_live     (int_live),
  .pwr_evt      (pwr_evt)
);

// File: tb/tb_lkw_wake_gen.sv
module tb_lkw_wake_gen;
  localparam int CLK_PERIOD = 20;
  localparam int HALF       = 4;
  localparam int TO         = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lps = 1'b0, lctl = 1'b0, pkt = 1'b0;
  logic       irq_pe = 1'b0, irq_cfg = 1'b0, irq_cbl = 1'b0, irq_st = 1'b0, irq_en = 1'b0;
  logic       pwr = 1'b0;
  logic [2:0] pclass = 3'd0;
  logic       brst = 1'b0;
  logic       wake_o, wake_oe_o;
  int         n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lkw_wake_gen #(.HALF_CYC(HALF), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n),
    .link_pwr_on_i(lps), .link_ctl_en_i(lctl), .wake_pkt_i(pkt),
    .irq_port_event_i(irq_pe), .irq_cfg_timeout_i(irq_cfg),
    .irq_cable_pwr_i(irq_cbl), .irq_state_timeout_i(irq_st),
    .irq_resume_en_i(irq_en), .pwr_cycle_i(pwr), .pwr_class_i(pclass),
    .bus_reset_i(brst), .wake_o(wake_o), .wake_oe_o(wake_oe_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic wave_at(input int k);
    return ((k / HALF) % 2) == 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // k counts cycles since the edge that latched the cause
  task automatic run_wave(input int k0, input int n, input string req);
    for (int k = k0; k < k0 + n; k++) begin
      check(wake_o, wave_at(k), req);
      tick();
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(wake_o, 1'b0, req);
      tick();
    end
  endtask

  task automatic stop_link(input int k, input string req);
    lps = 1'b1; lctl = 1'b1;
    check(wake_o, wave_at(k), req);
    tick();
    check(wake_o, 1'b0, "R5");
    lps = 1'b0; lctl = 1'b0;
    tick();
    check(wake_o, 1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick();
    check(wake_oe_o, 1'b0, "R1");
    check(wake_o, 1'b0, "R1");
    tick();
    rst_n = 1'b1;
    tick();
    check(wake_oe_o, 1'b1, "R1");
    quiet(6, "R2");

    // packet cause across link-state combinations (R4, R5, R3)
    for (int m = 0; m < 4; m++) begin
      lps = m[0]; lctl = m[1];
      pkt = 1'b1;
      tick();
      pkt = 1'b0;
      if (m == 3) begin
        quiet(6, "R5");
        lps = 1'b0; lctl = 1'b0;
        tick();
        quiet(4, "R4");
      end else begin
        run_wave(0, 12, "R3");
        stop_link(12, "R4");
        quiet(4, "R4");
      end
    end

    // interrupt sweep: bit b with enable en (R6, R7, R13)
    for (int b = 0; b < 4; b++) begin
      for (int en = 0; en < 2; en++) begin
        irq_pe = (b == 0); irq_cfg = (b == 1); irq_cbl = (b == 2); irq_st = (b == 3);
        irq_en = en[0];
        tick();
        if (b == 0 || en == 1) begin
          run_wave(0, 10, (b == 0) ? "R6" : "R7");
          irq_pe = 0; irq_cfg = 0; irq_cbl = 0; irq_st = 0; irq_en = 0;
          run_wave(10, 10, "R13");
          stop_link(20, "R13");
        end else begin
          quiet(6, "R7");
          irq_pe = 0; irq_cfg = 0; irq_cbl = 0; irq_st = 0; irq_en = 0;
          tick();
        end
      end
    end

    // power-class sweep (R8, R9)
    for (int c = 0; c < 8; c++) begin
      pclass = 3'(c);
      pwr = 1'b1;
      tick();
      pwr = 1'b0;
      if (c <= 4) begin
        run_wave(0, TO, "R8");
        quiet(4, "R9");
      end else begin
        quiet(6, "R8");
      end
    end

    // expiry edge coincides with a new interrupt (R9)
    pclass = 3'd2; pwr = 1'b1;
    tick();
    pwr = 1'b0;
    run_wave(0, TO - 1, "R9");
    irq_pe = 1'b1;
    run_wave(TO - 1, 1, "R9");
    irq_pe = 1'b0;
    run_wave(TO, 16, "R9");
    stop_link(TO + 16, "R9");

    // bus reset: packet only (R10)
    pkt = 1'b1;
    tick();
    pkt = 1'b0;
    run_wave(0, 6, "R10");
    brst = 1'b1;
    run_wave(6, 1, "R10");
    brst = 1'b0;
    quiet(4, "R10");

    // bus reset in the same cycle as a packet pulse (R10)
    pkt = 1'b1; brst = 1'b1;
    tick();
    pkt = 1'b0; brst = 1'b0;
    quiet(6, "R10");

    // bus reset with packet plus interrupt (R10)
    pkt = 1'b1; irq_pe = 1'b1;
    tick();
    pkt = 1'b0; irq_pe = 1'b0;
    run_wave(0, 6, "R10");
    brst = 1'b1;
    run_wave(6, 1, "R10");
    brst = 1'b0;
    run_wave(7, 9, "R10");
    stop_link(16, "R10");

    // bus reset with packet plus power cycle (R10)
    pkt = 1'b1; pwr = 1'b1; pclass = 3'd0;
    tick();
    pkt = 1'b0; pwr = 1'b0;
    run_wave(0, 6, "R10");
    brst = 1'b1;
    run_wave(6, 1, "R10");
    brst = 1'b0;
    run_wave(7, 9, "R10");
    stop_link(16, "R10");

    // interrupt pending while link active, then link drops (R11, R12)
    lps = 1'b1; lctl = 1'b1; irq_pe = 1'b1;
    tick();
    quiet(6, "R11");
    lctl = 1'b0;
    tick();
    run_wave(0, 14, "R11");
    lctl = 1'b1;
    check(wake_o, wave_at(14), "R11");
    tick();
    quiet(3, "R5");
    lctl = 1'b0;
    tick();
    run_wave(0, 8, "R12");
    irq_pe = 1'b0;
    stop_link(8, "R12");
    quiet(4, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule